// File: doc/BRIEF.md
# Flash Program/Erase Status Polling Logic

This block produces the status word a NOR flash returns while an embedded program or erase is running. Each cycle a controller supplies a set of operation-state flags: a word program is busy, a program was issued while an erase is held, the erase timeout window is open, an erase is running, or an erase is suspended. It also supplies the data bit being programmed, a time-limit-exceeded flag, a flag saying the addressed block is the one being erased or suspended, a completion pulse and a read strobe. The block registers the operating mode and drives the status bits that software polls: a complemented data bit, two bits that toggle on each read, a bit for the erase timeout window and a failure bit. When no status applies, it passes array data through.

The block returns to array-read mode by itself when an operation completes. It also holds the 16-bit configuration word with its power-up defaults, and it handles the active-low reset/power-down pin. That pin aborts a running operation. When the configuration allows it, the pin also takes the data outputs to high impedance. All pins are plain control and status signals. No pin carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `flash_status_poll`

## Requirements
- R1: After reset, `in_array` is 1, `cfg_q` is 16'h8000 (bit 15 page mode = 1, bit 14 inversion = 0, bit 10 power-down enable = 0), `dq_oe` is 1 and `dq_o` equals `arr_q`.
- R2: In program mode (`pgm_busy` or `pgm_in_susp`), `dq_o[7]` = ~`wr_bit`, `dq_o[6]` toggles, `dq_o[5]` = `tmo_fail`, `dq_o[3]` = 0 and `dq_o[2]` = 1.
- R3: In the erase timeout window (`ers_window` only), `dq_o[7]`, `dq_o[5]`, `dq_o[3]` and `dq_o[2]` are 0, and `dq_o[6]` toggles.
- R4: While an erase is running (`ers_active`), `dq_o[7]` = 0, `dq_o[6]` toggles, `dq_o[3]` = 1 and `dq_o[5]` = `tmo_fail`. `dq_o[2]` toggles only when `tmo_fail` and `addr_hit` are both 1; otherwise it is 0.
- R5: In erase suspend (`ers_susp`), a read of the suspended block (`addr_hit` = 1) gives `dq_o[7:5]` = 3'b110, `dq_o[3]` = 0 and a toggling `dq_o[2]`. A read of any other block gives `arr_q`.
- R6: A toggling bit starts at 0 each time an operation is entered and inverts on every rising edge of `rd_stb` seen at a clock edge. It keeps its value between reads. `dq_o[4]`, `dq_o[1]` and `dq_o[0]` are 0 in every status word.
- R7: The status follows the operation flags one clock after they are applied. Priority, from highest: program (`pgm_in_susp` or `pgm_busy`), then `ers_susp`, then `ers_active`, then `ers_window`.
- R8: The clock edge that samples `op_done` puts the block in array mode (`in_array` = 1, `dq_o` = `arr_q`). It stays there while any operation flag remains high, and it re-arms once all flags are low.
- R9: With `rp_n` low while not in array mode, the next edge returns the block to array mode and raises `op_abort` for one cycle.
- R10: When `rp_n` is low and `cfg_q[10]` is 1, `dq_oe` is 0 and `dq_o` is 0. When `cfg_q[10]` is 0, the outputs stay enabled.
- R11: When `cfg_we` is high at a clock edge, `cfg_q` takes the value of `cfg_wd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| pgm_busy | input | 1 | Word program in progress |
| pgm_in_susp | input | 1 | Program issued during erase suspend |
| ers_window | input | 1 | Erase timeout window open |
| ers_active | input | 1 | Block/chip erase running |
| ers_susp | input | 1 | Erase suspended |
| tmo_fail | input | 1 | Time limit exceeded |
| op_done | input | 1 | Operation completed successfully |
| wr_bit | input | 1 | Data bit being programmed |
| addr_hit | input | 1 | Addressed block is the erasing/suspended one |
| rd_stb | input | 1 | Read strobe; a rising edge is one read access |
| arr_q | input | DQ_W | Array read data |
| rp_n | input | 1 | Active-low reset/power-down pin |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wd | input | CFG_W | Configuration write data |
| dq_o | output | DQ_W | Status or array data |
| dq_oe | output | 1 | Output enable (0 = high impedance) |
| in_array | output | 1 | Block is in array-read mode |
| op_abort | output | 1 | One-cycle pulse: operation aborted by rp_n |
| cfg_q | output | CFG_W | Configuration word |

## Verification
The operation flags pass through one mode register. The bench applies them just after a falling edge and samples one rising edge later, at the following falling edge. A read strobe raised in the same way flips the toggle bits at the next rising edge. The bench therefore samples after that edge, and again one idle cycle later to confirm the bits held. `op_abort` and the return to array mode are due one edge after `rp_n` falls or `op_done` is sampled. Power-down high impedance is combinational from `rp_n`. Every case is checked at those exact points against a status word the bench computes from the mode, data bit, failure flag, block hit and read count.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    MD_ARRAY = 3'd0,
    MD_PGM   = 3'd1,
    MD_EWIN  = 3'd2,
    MD_ERUN  = 3'd3,
    MD_SUSP  = 3'd4
  } mode_e;

  localparam int TOG_N  = 2;  // toggle bit count
  localparam int TOG_D6 = 0;  // toggle feeding dq bit 6
  localparam int TOG_D2 = 1;  // toggle feeding dq bit 2
endpackage

// File: rtl/fsp_mode_ctl.sv
module fsp_mode_ctl
  import fsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pgm_busy,
  input  logic  pgm_in_susp,
  input  logic  ers_window,
  input  logic  ers_active,
  input  logic  ers_susp,
  input  logic  op_done,
  input  logic  rp_n,
  output mode_e mode_q,
  output logic  abort_q
);
  logic  any_op;
  logic  hold_q;
  logic  kill;
  mode_e dec;
  mode_e mode_d;

  assign any_op = pgm_busy | pgm_in_susp | ers_window | ers_active | ers_susp;
  assign kill   = op_done | hold_q | ~rp_n;

  always_comb begin
    if (pgm_in_susp || pgm_busy) dec = MD_PGM;
    else if (ers_susp)           dec = MD_SUSP;
    else if (ers_active)         dec = MD_ERUN;
    else if (ers_window)         dec = MD_EWIN;
    else                         dec = MD_ARRAY;
    mode_d = kill ? MD_ARRAY : dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_ARRAY;
      hold_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      hold_q  <= (op_done | hold_q) & any_op;
      abort_q <= ~rp_n & (mode_q != MD_ARRAY);
    end
  end

  // R8
  done_to_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (mode_q == MD_ARRAY));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && any_op) |=> ##1 (mode_q == MD_ARRAY));

  // R9
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_n && mode_q != MD_ARRAY) |=> (abort_q && mode_q == MD_ARRAY));
endmodule

// File: rtl/fsp_toggle.sv
module fsp_toggle #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_rise,
  input  logic         clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] tog_q
);
  for (genvar i = 0; i < N; i++) begin : g_tog
    always_ff @(posedge clk) begin
      if (!rst_n)                tog_q[i] <= 1'b0;
      else if (clr)              tog_q[i] <= 1'b0;
      else if (rd_rise && en[i]) tog_q[i] <= ~tog_q[i];
    end

    // R6
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_rise && !clr) |=> $stable(tog_q[i]));

    // R6
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && en[i] && !clr) |=> (tog_q[i] != $past(tog_q[i])));
  end
endmodule

// File: rtl/fsp_cfg_pwr.sv
module fsp_cfg_pwr #(
  parameter int              CFG_W     = 16,
  parameter int              PD_BIT    = 10,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wd,
  input  logic             rp_n,
  output logic [CFG_W-1:0] cfg_q,
  output logic             pd_act
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_wd;
  end

  assign pd_act = ~rp_n & cfg_q[PD_BIT];

  // R11
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wd)));

  // R11
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll
  import fsp_pkg::*;
#(
  parameter int              DQ_W      = 8,
  parameter int              CFG_W     = 16,
  parameter int              PD_BIT    = 10,
  parameter logic [CFG_W-1:0] CFG_RESET = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgm_busy,
  input  logic             pgm_in_susp,
  input  logic             ers_window,
  input  logic             ers_active,
  input  logic             ers_susp,
  input  logic             tmo_fail,
  input  logic             op_done,
  input  logic             wr_bit,
  input  logic             addr_hit,
  input  logic             rd_stb,
  input  logic [DQ_W-1:0]  arr_q,
  input  logic             rp_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wd,
  output logic [DQ_W-1:0]  dq_o,
  output logic             dq_oe,
  output logic             in_array,
  output logic             op_abort,
  output logic [CFG_W-1:0] cfg_q
);
  mode_e             mode_q;
  logic              rd_prev;
  logic              rd_rise;
  logic [TOG_N-1:0]  tog_en;
  logic [TOG_N-1:0]  tog_q;
  logic              pd_act;
  logic              erun_fail_hit;
  logic [DQ_W-1:0]   st;

  fsp_mode_ctl u_mode (
    .clk, .rst_n, .pgm_busy, .pgm_in_susp, .ers_window, .ers_active,
    .ers_susp, .op_done, .rp_n, .mode_q, .abort_q(op_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rd_prev <= 1'b0;
    else        rd_prev <= rd_stb;
  end
  assign rd_rise = rd_stb & ~rd_prev;

  assign erun_fail_hit  = (mode_q == MD_ERUN) & tmo_fail & addr_hit;
  assign tog_en[TOG_D6] = (mode_q == MD_PGM) | (mode_q == MD_EWIN) | (mode_q == MD_ERUN);
  assign tog_en[TOG_D2] = ((mode_q == MD_SUSP) & addr_hit) | erun_fail_hit;

  fsp_toggle #(.N(TOG_N)) u_tog (
    .clk, .rst_n, .rd_rise, .clr(mode_q == MD_ARRAY), .en(tog_en), .tog_q
  );

  fsp_cfg_pwr #(.CFG_W(CFG_W), .PD_BIT(PD_BIT), .CFG_RESET(CFG_RESET)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_wd, .rp_n, .cfg_q, .pd_act
  );

  always_comb begin
    st = '0;
    unique case (mode_q)
      MD_PGM: begin
        st[7] = ~wr_bit;
        st[6] = tog_q[TOG_D6];
        st[5] = tmo_fail;
        st[2] = 1'b1;
      end
      MD_EWIN: st[6] = tog_q[TOG_D6];
      MD_ERUN: begin
        st[6] = tog_q[TOG_D6];
        st[5] = tmo_fail;
        st[3] = 1'b1;
        st[2] = erun_fail_hit & tog_q[TOG_D2];
      end
      MD_SUSP: begin
        if (addr_hit) begin
          st[7] = 1'b1;
          st[6] = 1'b1;
          st[2] = tog_q[TOG_D2];
        end else begin
          st = arr_q;
        end
      end
      default: st = arr_q;
    endcase
  end

  assign dq_o     = pd_act ? '0 : st;
  assign dq_oe    = ~pd_act;
  assign in_array = (mode_q == MD_ARRAY);

  // R2
  pgm_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PGM && dq_oe) |-> (dq_o[2] && !dq_o[3] && !dq_o[4]));

  // R5
  susp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SUSP && addr_hit && dq_oe) |-> (dq_o[7:5] == 3'b110));

  // R10
  pd_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rp_n && cfg_q[PD_BIT]) |-> (!dq_oe && dq_o == '0));

  // R4
  erun_dq3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ERUN && dq_oe) |-> (dq_o[3] && !dq_o[7]));
endmodule

// File: tb/sim_flash_status_poll.sv
module sim_flash_status_poll;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        pgm_busy = 0, pgm_in_susp = 0, ers_window = 0, ers_active = 0, ers_susp = 0;
  logic        tmo_fail = 0, op_done = 0, wr_bit = 0, addr_hit = 0, rd_stb = 0;
  logic [7:0]  arr_q = 8'h3C;
  logic        rp_n = 1'b1, cfg_we = 1'b0;
  logic [15:0] cfg_wd = '0;
  logic [7:0]  dq_o;
  logic        dq_oe, in_array, op_abort;
  logic [15:0] cfg_q;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  flash_status_poll u0 (
    .clk, .rst_n, .pgm_busy, .pgm_in_susp, .ers_window, .ers_active, .ers_susp,
    .tmo_fail, .op_done, .wr_bit, .addr_hit, .rd_stb, .arr_q, .rp_n, .cfg_we,
    .cfg_wd, .dq_o, .dq_oe, .in_array, .op_abort, .cfg_q
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_ops(input int md);
    pgm_busy    = (md == 0);
    pgm_in_susp = (md == 1);
    ers_susp    = (md == 1) || (md == 4);
    ers_window  = (md == 2);
    ers_active  = (md == 3);
  endtask

  // Status word per requirement: md 0/1 program, 2 window, 3 running, 4 suspend
  function automatic logic [7:0] exp_st(int md, bit w, bit t, bit h, int n, logic [7:0] a);
    logic p;
    p = n[0];
    case (md)
      0, 1: return {~w, p, t, 1'b0, 1'b0, 1'b1, 2'b00};
      2:    return {1'b0, p, 6'b0};
      3:    return {1'b0, p, t, 1'b0, 1'b1, (t & h) ? p : 1'b0, 2'b00};
      default: return h ? {3'b110, 2'b00, p, 2'b00} : a;
    endcase
  endfunction

  function automatic string tag(int md);
    case (md)
      0:       return "R2";
      1:       return "R2/R7";
      2:       return "R3";
      3:       return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset defaults
    check("R1 in_array", 16'(in_array), 16'd1);
    check("R1 cfg", cfg_q, 16'h8000);
    check("R1 oe", 16'(dq_oe), 16'd1);
    check("R1 dq", 16'(dq_o), 16'(arr_q));

    // Sweep of modes x data bit x fail x block hit
    for (int md = 0; md < 5; md++) begin
      for (int c = 0; c < 8; c++) begin
        set_ops(-1);
        tick();
        tick();
        wr_bit = c[0];
        tmo_fail = c[1];
        addr_hit = c[2];
        arr_q = 8'(8'h5A ^ (md * 8 + c));
        set_ops(md);
        tick();
        // R7 one-cycle latency, toggles start at 0 (R6)
        check({tag(md), " R7 entry"}, 16'(dq_o),
              16'(exp_st(md, wr_bit, tmo_fail, addr_hit, 0, arr_q)));
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
        check({tag(md), " R6 read1"}, 16'(dq_o),
              16'(exp_st(md, wr_bit, tmo_fail, addr_hit, 1, arr_q)));
        tick();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
        check({tag(md), " R6 read2"}, 16'(dq_o),
              16'(exp_st(md, wr_bit, tmo_fail, addr_hit, 2, arr_q)));
        tick();
        tick();
        check({tag(md), " R6 hold"}, 16'(dq_o),
              16'(exp_st(md, wr_bit, tmo_fail, addr_hit, 2, arr_q)));
      end
    end

    // R8 completion returns to array and stays while flags remain
    set_ops(-1);
    tick();
    arr_q = 8'hC3;
    set_ops(0);
    tick();
    check("R8 busy", 16'(in_array), 16'd0);
    op_done = 1'b1;
    tick();
    op_done = 1'b0;
    check("R8 done", 16'(in_array), 16'd1);
    check("R8 data", 16'(dq_o), 16'hC3);
    tick();
    tick();
    check("R8 sticky", 16'(in_array), 16'd1);
    set_ops(-1);
    tick();
    set_ops(0);
    tick();
    check("R8 rearm", 16'(in_array), 16'd0);

    // R9 abort
    set_ops(3);
    tick();
    rp_n = 1'b0;
    tick();
    check("R9 abort", 16'(op_abort), 16'd1);
    check("R9 array", 16'(in_array), 16'd1);
    check("R10 oe pd off", 16'(dq_oe), 16'd1);
    tick();
    check("R9 pulse", 16'(op_abort), 16'd0);
    rp_n = 1'b1;
    set_ops(-1);
    tick();

    // R11 config write, R10 power-down
    cfg_wd = 16'h8400;
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
    check("R11 cfg", cfg_q, 16'h8400);
    rp_n = 1'b0;
    #1;
    check("R10 oe", 16'(dq_oe), 16'd0);
    check("R10 dq", 16'(dq_o), 16'd0);
    tick();
    rp_n = 1'b1;
    #1;
    check("R10 oe back", 16'(dq_oe), 16'd1);
    tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule